// File: doc/BRIEF.md
# Mesh 3x2 Switch Element

This block is a single routing node of an acyclic sparse-mesh fabric that moves shared-memory traffic. Three streams come in: one from the preceding column, one from the local switch and one from the row. Two streams go out: one toward the next column and one toward the attached resource. Each output owns a queue that can absorb up to three messages in a single cycle, one per input. A fixed-priority admission stage fills the queues, and any input it cannot admit sees its ready low and holds its message.

A message is a word whose two top bits carry its kind: 0 means empty, 1 means read or read reply, 2 means write, 3 means step synchronization. Below the kind sits the target row field (ROW_W bits), then the target column field (COL_W bits), then the payload. Reads and writes whose target row equals `my_row` turn toward the resource, and all others continue to the next column. Step synchronization markers are gathered from all three inputs and then leave as a single marker on each output. This keeps traffic from consecutive steps apart.

All streams use valid/ready. A sender keeps valid and data steady until it sees ready high at a clock edge. Ready may depend on valid in the same cycle. Each output keeps valid and data stable while its ready is low.

Top module: `swe_mesh_3x2`

## Requirements
- R1: After reset both output queues are empty, so `nxt_valid` and `res_valid` are low.
- R2: A read (kind 1) or write (kind 2) whose row field (bits W-3 down to W-2-ROW_W) equals `my_row` leaves on the resource output. Any other row value leaves on the next-column output. The data word is unchanged.
- R3: In one cycle a queue can accept one message from each of the three inputs. Those messages enter in the order column, local, row, and each output delivers its messages in the order they entered.
- R4: Free space is taken as it stands at the start of the cycle. When more inputs contend for a queue than it has free slots, the inputs win in the order column, local, row, and the losers see ready low.
- R5: A queue holds at most DEPTH messages. While it is full, every input aimed at it sees ready low. The cycle after a pop frees a slot, a waiting input is accepted.
- R6: An empty message (kind 0) is accepted and discarded. It never appears on either output.
- R7: After an input delivers a synchronization message (kind 3), that input's ready stays low until the markers have been merged. Later messages on that input wait behind the marker.
- R8: Once all three inputs have delivered a marker, one marker (kind 3, all other bits 0) is written into both queues on the next clock edge. The held inputs are then released, and their messages queue behind the marker.
- R9: While an output's ready is low, its valid stays high and its data stays unchanged.
- R10: A message accepted into an empty queue appears on that output in the cycle right after it is accepted.
- R11: The merged marker is written only when both queues have a free slot. Until then it is deferred, and no marker appears on either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| my_row | input | ROW_W | Row index of this element, used for steering |
| col_in_valid | input | 1 | Message valid from the previous column |
| col_in_ready | output | 1 | Column input accepted at this edge |
| col_in_data | input | W | Message from the previous column |
| loc_in_valid | input | 1 | Message valid from the local switch |
| loc_in_ready | output | 1 | Local input accepted at this edge |
| loc_in_data | input | W | Message from the local switch |
| row_in_valid | input | 1 | Message valid from the row |
| row_in_ready | output | 1 | Row input accepted at this edge |
| row_in_data | input | W | Message from the row |
| nxt_valid | output | 1 | Head of the next-column queue is valid |
| nxt_ready | input | 1 | Next column takes the head |
| nxt_data | output | W | Head of the next-column queue |
| res_valid | output | 1 | Head of the resource queue is valid |
| res_ready | input | 1 | Resource takes the head |
| res_data | output | W | Head of the resource queue |

## Verification
A message accepted at clock edge t can be seen on its output after edge t, so the bench samples one cycle after a lone injection. Merged markers pass through one more register: the last marker accepted at edge t leaves on both outputs after edge t+1, and a released input's held message follows after edge t+2. A slot freed by a pop at edge t makes the waiting input ready during the following cycle. Inputs are driven on the falling edge, ready is read 1 ns later, and outputs are checked on the falling edges that follow, each at the exact cycle counted above. Long drains of a queue are checked one message per cycle in strict order.

// File: rtl/swe_pkg.sv
package swe_pkg;
  typedef enum logic [1:0] {
    MK_EMPTY = 2'd0,
    MK_READ  = 2'd1,
    MK_WRITE = 2'd2,
    MK_SYNC  = 2'd3
  } msg_kind_e;

  localparam int N_IN = 3;  // column, local, row, in priority order
endpackage

// File: rtl/swe_mqueue.sv
module swe_mqueue #(
  parameter int DEPTH = 16,
  parameter int W     = 34,
  parameter int NWR   = 3,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NWR-1:0]          wr_vld,   // packed from port 0 upward
  input  logic [NWR-1:0][W-1:0]   wr_data,
  output logic [CW-1:0]           free,
  output logic                    rd_valid,
  input  logic                    rd_ready,
  output logic [W-1:0]            rd_data
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rptr, wptr;
  logic [CW-1:0] cnt, nwr;
  logic          pop;

  always_comb begin
    nwr = '0;
    for (int k = 0; k < NWR; k++) nwr = nwr + CW'(wr_vld[k]);
  end

  assign pop      = rd_valid & rd_ready;
  assign rd_valid = (cnt != '0);
  assign rd_data  = mem[rptr];
  assign free     = CW'(DEPTH) - cnt;

  always_ff @(posedge clk) begin
    for (int k = 0; k < NWR; k++)
      if (wr_vld[k]) mem[wptr + AW'(k)] <= wr_data[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr <= '0;
      wptr <= '0;
      cnt  <= '0;
    end else begin
      wptr <= wptr + AW'(nwr);
      rptr <= rptr + AW'(pop);
      cnt  <= cnt + nwr - CW'(pop);
    end
  end
endmodule

// File: rtl/swe_admit.sv
module swe_admit
  import swe_pkg::*;
#(
  parameter int ROW_W = 4,
  parameter int W     = 34,
  parameter int CW    = 5,
  parameter int NIN   = N_IN,
  localparam int IW   = $clog2(NIN + 1)
) (
  input  logic [ROW_W-1:0]        my_row,
  input  logic [NIN-1:0]          in_valid,
  input  logic [NIN-1:0][W-1:0]   in_data,
  input  logic [NIN-1:0]          held,
  input  logic                    block,
  input  logic [CW-1:0]           free_n,
  input  logic [CW-1:0]           free_r,
  output logic [NIN-1:0]          in_ready,
  output logic [NIN-1:0]          sync_take,
  output logic [NIN-1:0]          wn_vld,
  output logic [NIN-1:0][W-1:0]   wn_data,
  output logic [NIN-1:0]          wr_vld,
  output logic [NIN-1:0][W-1:0]   wr_data
);
  logic [IW-1:0] cn, cr;

  always_comb begin
    in_ready  = '0;
    sync_take = '0;
    wn_vld    = '0;
    wn_data   = '0;
    wr_vld    = '0;
    wr_data   = '0;
    cn        = '0;
    cr        = '0;
    for (int i = 0; i < NIN; i++) begin
      msg_kind_e kind;
      logic      to_res;
      kind   = msg_kind_e'(in_data[i][W-1 -: 2]);
      to_res = (in_data[i][W-3 -: ROW_W] == my_row);
      if (in_valid[i] && !held[i] && !block) begin
        unique case (kind)
          MK_EMPTY: in_ready[i] = 1'b1;
          MK_SYNC: begin
            in_ready[i]  = 1'b1;
            sync_take[i] = 1'b1;
          end
          default: begin
            if (to_res) begin
              if (CW'(cr) < free_r) begin
                in_ready[i]   = 1'b1;
                wr_vld[cr]    = 1'b1;
                wr_data[cr]   = in_data[i];
                cr            = cr + 1'b1;
              end
            end else begin
              if (CW'(cn) < free_n) begin
                in_ready[i]   = 1'b1;
                wn_vld[cn]    = 1'b1;
                wn_data[cn]   = in_data[i];
                cn            = cn + 1'b1;
              end
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/swe_sync_merge.sv
module swe_sync_merge
  import swe_pkg::*;
#(
  parameter int NIN = N_IN,
  parameter int CW  = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NIN-1:0] take,
  input  logic [CW-1:0]  free_n,
  input  logic [CW-1:0]  free_r,
  output logic [NIN-1:0] held,
  output logic           all_seen,
  output logic           push
);
  logic [NIN-1:0] seen;

  assign held     = seen;
  assign all_seen = &seen;
  assign push     = all_seen && (free_n != '0) && (free_r != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    seen <= '0;
    else if (push) seen <= '0;
    else           seen <= seen | take;
  end
endmodule

// File: rtl/swe_mesh_3x2.sv
module swe_mesh_3x2
  import swe_pkg::*;
#(
  parameter int ROW_W = 4,
  parameter int COL_W = 4,
  parameter int PAY_W = 28,
  parameter int DEPTH = 16,
  localparam int W    = 2 + ROW_W + COL_W + PAY_W,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ROW_W-1:0] my_row,
  input  logic             col_in_valid,
  output logic             col_in_ready,
  input  logic [W-1:0]     col_in_data,
  input  logic             loc_in_valid,
  output logic             loc_in_ready,
  input  logic [W-1:0]     loc_in_data,
  input  logic             row_in_valid,
  output logic             row_in_ready,
  input  logic [W-1:0]     row_in_data,
  output logic             nxt_valid,
  input  logic             nxt_ready,
  output logic [W-1:0]     nxt_data,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [W-1:0]     res_data
);
  localparam logic [W-1:0] SYNC_MSG = {MK_SYNC, {(W-2){1'b0}}};

  logic [N_IN-1:0]         in_v, in_r, held, take;
  logic [N_IN-1:0][W-1:0]  in_d;
  logic [N_IN-1:0]         an_vld, ar_vld, qn_vld, qr_vld;
  logic [N_IN-1:0][W-1:0]  an_data, ar_data, qn_data, qr_data;
  logic [CW-1:0]           qn_free, qr_free;
  logic                    all_seen, push;

  assign in_v = {row_in_valid, loc_in_valid, col_in_valid};
  assign in_d = {row_in_data, loc_in_data, col_in_data};
  assign col_in_ready = in_r[0];
  assign loc_in_ready = in_r[1];
  assign row_in_ready = in_r[2];

  swe_admit #(.ROW_W(ROW_W), .W(W), .CW(CW), .NIN(N_IN)) u_admit (
    .my_row(my_row), .in_valid(in_v), .in_data(in_d), .held(held),
    .block(all_seen), .free_n(qn_free), .free_r(qr_free),
    .in_ready(in_r), .sync_take(take),
    .wn_vld(an_vld), .wn_data(an_data), .wr_vld(ar_vld), .wr_data(ar_data)
  );

  swe_sync_merge #(.NIN(N_IN), .CW(CW)) u_merge (
    .clk(clk), .rst_n(rst_n), .take(take), .free_n(qn_free), .free_r(qr_free),
    .held(held), .all_seen(all_seen), .push(push)
  );

  // The merged marker takes write port 0 of both queues.
  always_comb begin
    qn_vld  = an_vld;
    qn_data = an_data;
    qr_vld  = ar_vld;
    qr_data = ar_data;
    if (push) begin
      qn_vld[0]  = 1'b1;
      qn_data[0] = SYNC_MSG;
      qr_vld[0]  = 1'b1;
      qr_data[0] = SYNC_MSG;
    end
  end

  swe_mqueue #(.DEPTH(DEPTH), .W(W), .NWR(N_IN)) u_qn (
    .clk(clk), .rst_n(rst_n), .wr_vld(qn_vld), .wr_data(qn_data),
    .free(qn_free), .rd_valid(nxt_valid), .rd_ready(nxt_ready), .rd_data(nxt_data)
  );

  swe_mqueue #(.DEPTH(DEPTH), .W(W), .NWR(N_IN)) u_qr (
    .clk(clk), .rst_n(rst_n), .wr_vld(qr_vld), .wr_data(qr_data),
    .free(qr_free), .rd_valid(res_valid), .rd_ready(res_ready), .rd_data(res_data)
  );
endmodule

// File: rtl/swe_checker.sv
module swe_checker #(
  parameter int W     = 34,
  parameter int ROW_W = 4,
  parameter int CW    = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [ROW_W-1:0] my_row,
  input logic             col_in_valid,
  input logic             col_in_ready,
  input logic [W-1:0]     col_in_data,
  input logic             nxt_valid,
  input logic             nxt_ready,
  input logic [W-1:0]     nxt_data,
  input logic             res_valid,
  input logic             res_ready,
  input logic [W-1:0]     res_data,
  input logic [2:0]       an_vld,
  input logic [2:0]       ar_vld,
  input logic [CW-1:0]    qn_free,
  input logic [CW-1:0]    qr_free,
  input logic             push
);
  wire [1:0] nk = nxt_data[W-1 -: 2];
  wire [1:0] rk = res_data[W-1 -: 2];
  wire [1:0] ck = col_in_data[W-1 -: 2];

  assert_hold_nxt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    nxt_valid && !nxt_ready |=> nxt_valid && $stable(nxt_data));
  assert_hold_res_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_data));
  assert_steer_res_R2: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && (rk == 2'd1 || rk == 2'd2) |-> res_data[W-3 -: ROW_W] == my_row);
  assert_steer_nxt_R2: assert property (@(posedge clk) disable iff (!rst_n)
    nxt_valid && (nk == 2'd1 || nk == 2'd2) |-> nxt_data[W-3 -: ROW_W] != my_row);
  assert_no_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (nxt_valid |-> nk != 2'd0) and (res_valid |-> rk != 2'd0));
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (CW'($countones(an_vld)) <= qn_free) && (CW'($countones(ar_vld)) <= qr_free));
  assert_pack_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((an_vld & (an_vld + 3'd1)) == 3'd0) && ((ar_vld & (ar_vld + 3'd1)) == 3'd0));
  assert_sync_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    col_in_valid && col_in_ready && ck == 2'd3 |=> !col_in_ready);
  assert_merge_alone_R8: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (an_vld == 3'd0) && (ar_vld == 3'd0));
endmodule

bind swe_mesh_3x2 swe_checker #(.W(W), .ROW_W(ROW_W), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .my_row(my_row),
  .col_in_valid(col_in_valid), .col_in_ready(col_in_ready), .col_in_data(col_in_data),
  .nxt_valid(nxt_valid), .nxt_ready(nxt_ready), .nxt_data(nxt_data),
  .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
  .an_vld(an_vld), .ar_vld(ar_vld), .qn_free(qn_free), .qr_free(qr_free), .push(push)
);

// File: tb/tb_swe_mesh_3x2.sv
module tb_swe_mesh_3x2;
  localparam int MW = 38;
  localparam logic [MW-1:0] SYNC = {2'd3, 36'd0};

  function automatic logic [MW-1:0] mk(logic [1:0] k, logic [3:0] r, logic [3:0] c, logic [27:0] p);
    return {k, r, c, p};
  endfunction

  // {src(2), dest(2: 0 next col, 1 resource, 2 none), message}
  localparam int NV = 9;
  localparam logic [MW+3:0] VEC [NV] = '{
    {2'd0, 2'd1, mk(2'd1, 4'd5,  4'd2, 28'h111)},
    {2'd0, 2'd0, mk(2'd2, 4'd3,  4'd1, 28'h222)},
    {2'd1, 2'd0, mk(2'd1, 4'd9,  4'd0, 28'h333)},
    {2'd1, 2'd1, mk(2'd2, 4'd5,  4'd4, 28'h444)},
    {2'd2, 2'd1, mk(2'd1, 4'd5,  4'd6, 28'h555)},
    {2'd2, 2'd0, mk(2'd2, 4'd0,  4'd7, 28'h666)},
    {2'd0, 2'd2, mk(2'd0, 4'd2,  4'd2, 28'h777)},
    {2'd2, 2'd2, mk(2'd0, 4'd5,  4'd3, 28'h888)},
    {2'd1, 2'd0, mk(2'd2, 4'd15, 4'd9, 28'h999)}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic [2:0] iv;
  logic [MW-1:0] idat [3];
  wire  [2:0] ird;
  logic nrdy, rrdy;
  wire  nv, rv;
  wire  [MW-1:0] nd, rd;
  int nchk = 0, nerr = 0;
  bit done = 0;

  always #2 clk = ~clk;

  swe_mesh_3x2 dut (
    .clk(clk), .rst_n(rst_n), .my_row(4'd5),
    .col_in_valid(iv[0]), .col_in_ready(ird[0]), .col_in_data(idat[0]),
    .loc_in_valid(iv[1]), .loc_in_ready(ird[1]), .loc_in_data(idat[1]),
    .row_in_valid(iv[2]), .row_in_ready(ird[2]), .row_in_data(idat[2]),
    .nxt_valid(nv), .nxt_ready(nrdy), .nxt_data(nd),
    .res_valid(rv), .res_ready(rrdy), .res_data(rd)
  );

  task automatic chk(input bit ok, input string req, input logic [MW-1:0] act, input logic [MW-1:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  endtask

  initial begin
    #800000;
    nerr++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [MW-1:0] head, m;
    bit got_res_sync;
    rst_n = 1'b0; iv = '0; nrdy = 1'b1; rrdy = 1'b1;
    for (int i = 0; i < 3; i++) idat[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!nv && !rv, "R1 outputs idle after reset", {36'd0, nv, rv}, '0);

    // Table walk: one message per vector, output due one cycle after acceptance
    for (int v = 0; v < NV; v++) begin
      int s, d;
      s = int'(VEC[v][MW+3:MW+2]);
      d = int'(VEC[v][MW+1:MW]);
      m = VEC[v][MW-1:0];
      iv[s] = 1'b1; idat[s] = m;
      #1 chk(ird[s], "R2 input accepted", {37'd0, ird[s]}, 1);
      @(negedge clk);
      iv[s] = 1'b0;
      if (d == 0)      chk(nv && nd == m && !rv, "R2 R10 next-column routing", nd, m);
      else if (d == 1) chk(rv && rd == m && !nv, "R2 R10 resource routing", rd, m);
      else             chk(!nv && !rv, "R6 empty dropped", {36'd0, nv, rv}, '0);
      @(negedge clk);
    end

    // R3: three messages into one queue in a single cycle, order kept
    idat[0] = mk(2'd1, 4'd5, 4'd0, 28'hA0);
    idat[1] = mk(2'd2, 4'd5, 4'd1, 28'hA1);
    idat[2] = mk(2'd1, 4'd5, 4'd2, 28'hA2);
    iv = 3'b111;
    #1 chk(ird == 3'b111, "R3 all three accepted", {35'd0, ird}, 3'b111);
    @(negedge clk);
    iv = '0;
    for (int i = 0; i < 3; i++) begin
      chk(rv && rd == idat[i], "R3 order col loc row", rd, idat[i]);
      @(negedge clk);
    end

    // R4 R5 R9: fill the resource queue, contention at the boundary
    rrdy = 1'b0;
    for (int k = 0; k < 14; k++) begin
      iv[1] = 1'b1; idat[1] = mk(2'd2, 4'd5, 4'd0, 28'(k));
      #1;
      @(negedge clk);
    end
    iv[1] = 1'b0;
    idat[0] = mk(2'd1, 4'd5, 4'd1, 28'hC0);
    idat[1] = mk(2'd1, 4'd5, 4'd2, 28'hC1);
    idat[2] = mk(2'd1, 4'd5, 4'd3, 28'hC2);
    iv = 3'b111;
    #1 chk(ird == 3'b011, "R4 two free slots go to col and loc", {35'd0, ird}, 3'b011);
    @(negedge clk);
    iv[1:0] = 2'b00;
    #1 chk(!ird[2], "R5 full queue busy", {37'd0, ird[2]}, 0);
    head = rd;
    chk(rv && rd == mk(2'd2, 4'd5, 4'd0, 28'd0), "R9 head valid while stalled", rd, mk(2'd2, 4'd5, 4'd0, 28'd0));
    repeat (2) @(negedge clk);
    chk(rv && rd == head && !ird[2], "R9 head stable and still busy", rd, head);
    rrdy = 1'b1;
    @(negedge clk);
    rrdy = 1'b0;
    #1 chk(ird[2], "R5 slot freed, waiting input accepted", {37'd0, ird[2]}, 1);
    @(negedge clk);
    iv[2] = 1'b0;
    rrdy = 1'b1;
    for (int k = 1; k < 17; k++) begin
      logic [MW-1:0] e;
      e = (k < 14) ? mk(2'd2, 4'd5, 4'd0, 28'(k)) : idat[k-14];
      chk(rv && rd == e, "R5 drain order", rd, e);
      @(negedge clk);
    end
    chk(!rv, "R5 queue empty after drain", {37'd0, rv}, 0);

    // R7 R8: marker merge and holding behind a marker
    iv[0] = 1'b1; idat[0] = SYNC;
    #1 chk(ird[0], "R7 marker accepted", {37'd0, ird[0]}, 1);
    @(negedge clk);
    idat[0] = mk(2'd1, 4'd5, 4'd7, 28'hAB);
    #1 chk(!ird[0], "R7 input held behind marker", {37'd0, ird[0]}, 0);
    @(negedge clk);
    chk(!ird[0] && !nv && !rv, "R8 no early marker", {35'd0, ird[0], nv, rv}, '0);
    iv[2:1] = 2'b11; idat[1] = SYNC; idat[2] = SYNC;
    #1 chk(ird[2:1] == 2'b11, "R7 remaining markers accepted", {36'd0, ird[2:1]}, 2'b11);
    @(negedge clk);
    iv[2:1] = 2'b00;
    chk(!nv && !rv && !ird[0], "R8 merge one cycle later", {35'd0, ird[0], nv, rv}, '0);
    @(negedge clk);
    chk(nv && nd == SYNC, "R8 marker on next column", nd, SYNC);
    chk(rv && rd == SYNC, "R8 marker on resource", rd, SYNC);
    chk(ird[0], "R8 held input released", {37'd0, ird[0]}, 1);
    @(negedge clk);
    iv[0] = 1'b0;
    chk(rv && rd == mk(2'd1, 4'd5, 4'd7, 28'hAB) && !nv, "R8 held message after marker", rd, mk(2'd1, 4'd5, 4'd7, 28'hAB));
    @(negedge clk);

    // R11: merge waits for room in the full next-column queue
    nrdy = 1'b0;
    for (int k = 0; k < 16; k++) begin
      iv[1] = 1'b1; idat[1] = mk(2'd2, 4'd1, 4'd0, 28'(k));
      #1;
      @(negedge clk);
    end
    iv = 3'b111;
    for (int i = 0; i < 3; i++) idat[i] = SYNC;
    #1 chk(ird == 3'b111, "R11 markers accepted", {35'd0, ird}, 3'b111);
    @(negedge clk);
    iv = '0;
    for (int c = 0; c < 3; c++) begin
      chk(!rv, "R11 marker deferred while queue full", {37'd0, rv}, 0);
      @(negedge clk);
    end
    nrdy = 1'b1;
    got_res_sync = 0;
    for (int k = 0; k < 16; k++) begin
      if (rv && rd == SYNC) got_res_sync = 1;
      chk(nv && nd == mk(2'd2, 4'd1, 4'd0, 28'(k)), "R11 drain before marker", nd, mk(2'd2, 4'd1, 4'd0, 28'(k)));
      @(negedge clk);
    end
    chk(got_res_sync, "R11 marker issued once room appeared", {37'd0, got_res_sync}, 1);
    chk(nv && nd == SYNC, "R11 marker follows drained queue", nd, SYNC);
    @(negedge clk);
    finish_run();
  end
endmodule